// File: doc/BRIEF.md
# Debug Entry and Trace Controller

This block decides when a processor core stops executing and halts into a debug state. Three triggers can cause a halt: an external request line that is already high while reset is held, the same line raised while the core is running, and a 16-bit trace counter that counts retired instructions down to a programmed stop point. Every halt is reported the same way. The block raises a halt request to the core, drives an active-low acknowledge enable toward the request pin, and sets the two-bit core status field to the debug code.

A debug host loads the trace counter through a simple write port and can read it back at any time. To stop after N instructions, the host loads N-1 and leaves debug with tracing enabled. After a halt, the host must first release its request line. Only then does the block raise its command-accept signal and honour the single-cycle exit strobe. An optional security mode, sampled during reset, makes the whole unit inert until the core writes the unlock strobe.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While rst_n is low on a clock edge with ext_req low, the block resets to run state: core_status 2'b00, halt_req 0, ack_oe_n 1, cnt_rdata 0, trace_hit 0, cmd_ok 0.
- R2: If ext_req is high and sec_en is low on the reset edges, the block leaves reset already halted: halt_req 1, core_status 2'b11, ack_oe_n 0, cmd_ok 0.
- R3: While running and unlocked, ext_req high together with instr_done high causes a halt from the following cycle. ext_req without instr_done causes no halt.
- R4: A cnt_wr pulse loads cnt_wdata into the counter, visible on cnt_rdata the next cycle. A write in the same cycle as a decrement takes precedence.
- R5: While tracing is armed and the block is running, each instr_done lowers a non-zero counter by exactly one.
- R6: A retire that finds an armed counter at zero causes a halt and sets trace_hit. A counter loaded with N-1 therefore halts after the N-th retire.
- R7: Each halt is shown at once on all three outputs: halt_req 1, core_status 2'b11 (debug) and ack_oe_n 0. The run code is 2'b00.
- R8: After every halt, cmd_ok stays 0 until ext_req has been sampled low on at least one clock edge in debug. It then reads 1.
- R9: exit_dbg is honoured only while cmd_ok is 1. It returns to run state (core_status 2'b00, trace_hit 0) and arms tracing only if trace_en is 1. An exit strobe given while cmd_ok is 0 leaves the block halted.
- R10: After an exit with trace_en 0, retires do not change the counter and never cause a halt.
- R11: If sec_en is high during reset, ext_req (at reset or in run) and cnt_wr are ignored until a unlock_wr pulse. After that pulse, requests work as normal.
- R12: When an external request and a trace expiry happen on the same retire, exactly one halt occurs and trace_hit is set.
- R13: While halted, instr_done does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_done | input | 1 | Strobe: one instruction retired this cycle |
| ext_req | input | 1 | External debug request line (sampled level) |
| sec_en | input | 1 | Security option enable, sampled during reset |
| unlock_wr | input | 1 | Core write strobe that releases the security lock |
| trace_en | input | 1 | Arm tracing on the next exit from debug |
| exit_dbg | input | 1 | Single-cycle strobe to leave debug state |
| cnt_wr | input | 1 | Trace counter write strobe |
| cnt_wdata | input | 16 | Trace counter write data |
| cnt_rdata | output | 16 | Trace counter read value |
| halt_req | output | 1 | Halt request to the core |
| ack_oe_n | output | 1 | Active-low drive enable for the acknowledge on the request pin |
| core_status | output | 2 | Core status field: 2'b00 run, 2'b11 debug |
| trace_hit | output | 1 | Trace occurrence flag |
| cmd_ok | output | 1 | Host commands may be accepted |

## Verification
Two things can fall in the same cycle. An external request can arrive on the very retire that takes an armed counter through zero. A counter write can also coincide with an armed decrement. The directed part loads the counter to zero and raises ext_req on the next retire, and separately writes the counter on a retire cycle. The random part also produces both overlaps with a mix of retire, request and write probabilities. A bench reference model judges each case: it expects a single halt with trace_hit set, and the written value rather than the decremented one.

// File: rtl/dbg_pkg.sv
// Package: shared encodings for the debug entry and trace controller.
// Assumes: the core decodes only the run and debug status codes.
package dbg_pkg;

    // Core status field codes shown to the core and the debug host.
    typedef enum logic [1:0] {
        CST_RUN   = 2'b00,
        CST_DEBUG = 2'b11
    } core_st_t;

    // Default trace counter width.
    localparam int TRACE_W = 16;

endpackage

// File: rtl/dbg_trace_cnt.sv
// Module: dbg_trace_cnt
// Down counter of retired instructions. A write has priority over a
// decrement in the same cycle. Assumes dec_en is given only when the
// count is non-zero (the sequencer gates it), so no wrap occurs.
module dbg_trace_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         dec_en,
    output logic [W-1:0] count,
    output logic         zero
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Counter register: clear on reset, load on write, else step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wdata;
        end else if (dec_en) begin
            count <= count - ONE;
        end
    end

    // Zero detect, used by the sequencer to fire the trace halt.
    always_comb begin
        zero = (count == '0);
    end

endmodule

// File: rtl/dbg_entry_seq.sv
// Module: dbg_entry_seq
// Debug entry sequencer. It holds the halted state, the security lock,
// the trace arm bit, the request-release tracker and the trace flag.
// Assumes instr_done marks a retire in the current cycle, so a halt
// taken on that edge lands between instructions.
module dbg_entry_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_done,
    input  logic ext_req,
    input  logic sec_en,
    input  logic unlock_wr,
    input  logic exit_dbg,
    input  logic trace_en,
    input  logic cnt_zero,
    output logic in_dbg,
    output logic locked,
    output logic armed,
    output logic cmd_ok,
    output logic trace_hit,
    output logic dec_en,
    output logic wr_allow
);

    logic req_seen_low;
    logic live;
    logic fire_ext;
    logic fire_trace;
    logic take_exit;

    // Trigger decode: which halt sources fire on this edge.
    always_comb begin
        live       = !in_dbg && !locked;
        fire_ext   = live && ext_req && instr_done;
        fire_trace = live && armed && instr_done && cnt_zero;
        dec_en     = live && armed && instr_done && !cnt_zero;
        wr_allow   = !locked;
        take_exit  = in_dbg && exit_dbg && req_seen_low;
        cmd_ok     = in_dbg && req_seen_low;
    end

    // Security lock: captured from sec_en in reset, dropped by unlock write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= sec_en;
        end else if (unlock_wr) begin
            locked <= 1'b0;
        end
    end

    // Halted state: request held in reset, run triggers, exit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_dbg <= ext_req && !sec_en;
        end else if (take_exit) begin
            in_dbg <= 1'b0;
        end else if (fire_ext || fire_trace) begin
            in_dbg <= 1'b1;
        end
    end

    // Trace arm bit: set on exit if enabled, dropped on any halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (take_exit) begin
            armed <= trace_en;
        end else if (fire_ext || fire_trace) begin
            armed <= 1'b0;
        end
    end

    // Request-release tracker: low-level of ext_req seen since the halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_seen_low <= 1'b0;
        end else if (!in_dbg || take_exit) begin
            req_seen_low <= 1'b0;
        end else if (!ext_req) begin
            req_seen_low <= 1'b1;
        end
    end

    // Trace occurrence flag: set by a trace halt, cleared on exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_hit <= 1'b0;
        end else if (take_exit) begin
            trace_hit <= 1'b0;
        end else if (fire_trace) begin
            trace_hit <= 1'b1;
        end
    end

endmodule

// File: rtl/dbg_status_enc.sv
// Module: dbg_status_enc
// Maps the halted state onto the core-facing outputs: status code,
// halt request and active-low acknowledge drive enable.
// Assumes in_dbg is a registered level.
module dbg_status_enc
    import dbg_pkg::*;
(
    input  logic       in_dbg,
    output logic [1:0] core_status,
    output logic       halt_req,
    output logic       ack_oe_n
);

    core_st_t st;

    // Status encoding and acknowledge drive from the halted state.
    always_comb begin
        st          = in_dbg ? CST_DEBUG : CST_RUN;
        core_status = st;
        halt_req    = in_dbg;
        ack_oe_n    = !in_dbg;
    end

endmodule

// File: rtl/dbg_entry_ctrl.sv
// Module: dbg_entry_ctrl (top)
// Debug entry and trace controller. It ties together the trace counter,
// the entry sequencer and the status encoder.
// Assumes a synchronous active-low reset and single-cycle strobes.
module dbg_entry_ctrl #(
    parameter int CNT_W = dbg_pkg::TRACE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done,
    input  logic             ext_req,
    input  logic             sec_en,
    input  logic             unlock_wr,
    input  logic             trace_en,
    input  logic             exit_dbg,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic             halt_req,
    output logic             ack_oe_n,
    output logic [1:0]       core_status,
    output logic             trace_hit,
    output logic             cmd_ok
);

    logic in_dbg;
    logic unit_locked;
    logic trace_armed;
    logic cnt_zero;
    logic dec_en;
    logic wr_allow;
    logic cnt_we;

    // Counter writes are dropped while the security lock is held.
    always_comb begin
        cnt_we = cnt_wr && wr_allow;
    end

    dbg_trace_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cnt_we),
        .wdata  (cnt_wdata),
        .dec_en (dec_en),
        .count  (cnt_rdata),
        .zero   (cnt_zero)
    );

    dbg_entry_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_done (instr_done),
        .ext_req    (ext_req),
        .sec_en     (sec_en),
        .unlock_wr  (unlock_wr),
        .exit_dbg   (exit_dbg),
        .trace_en   (trace_en),
        .cnt_zero   (cnt_zero),
        .in_dbg     (in_dbg),
        .locked     (unit_locked),
        .armed      (trace_armed),
        .cmd_ok     (cmd_ok),
        .trace_hit  (trace_hit),
        .dec_en     (dec_en),
        .wr_allow   (wr_allow)
    );

    dbg_status_enc u_enc (
        .in_dbg      (in_dbg),
        .core_status (core_status),
        .halt_req    (halt_req),
        .ack_oe_n    (ack_oe_n)
    );

endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
// Module: dbg_entry_ctrl_chk
// Property checker bound to dbg_entry_ctrl. It observes ports plus the
// lock and arm state of the top module.
module dbg_entry_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             instr_done,
    input logic             ext_req,
    input logic             exit_dbg,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic             halt_req,
    input logic [1:0]       core_status,
    input logic             trace_hit,
    input logic             cmd_ok,
    input logic             locked,
    input logic             armed
);

    // R3
    ext_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && ext_req && instr_done && !locked) |=> halt_req);

    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && armed && !locked && instr_done && !cnt_wr && cnt_rdata != '0)
        |=> (cnt_rdata == $past(cnt_rdata) - 1'b1));

    // R6
    hit_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trace_hit) |-> halt_req);

    // R8
    cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> !cmd_ok);

    // R9
    exit_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && exit_dbg && cmd_ok) |=> (!halt_req && core_status == 2'b00 && !trace_hit));

    // R13
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !cnt_wr) |=> $stable(cnt_rdata));

endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_done  (instr_done),
    .ext_req     (ext_req),
    .exit_dbg    (exit_dbg),
    .cnt_wr      (cnt_wr),
    .cnt_rdata   (cnt_rdata),
    .halt_req    (halt_req),
    .core_status (core_status),
    .trace_hit   (trace_hit),
    .cmd_ok      (cmd_ok),
    .locked      (unit_locked),
    .armed       (trace_armed)
);

// File: tb/dbg_entry_ctrl_test.sv
`timescale 1ns/100ps
module dbg_entry_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n, instr_done, ext_req, sec_en, unlock_wr, trace_en, exit_dbg, cnt_wr;
    logic [15:0] cnt_wdata, cnt_rdata;
    logic        halt_req, ack_oe_n, trace_hit, cmd_ok;
    logic [1:0]  core_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_valid = 1'b0;
    bit          m_dbg, m_locked, m_armed, m_seen, m_hit;
    logic [15:0] m_cnt;

    always #2.5 clk = ~clk;

    dbg_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .ext_req(ext_req),
        .sec_en(sec_en), .unlock_wr(unlock_wr), .trace_en(trace_en),
        .exit_dbg(exit_dbg), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .halt_req(halt_req), .ack_oe_n(ack_oe_n),
        .core_status(core_status), .trace_hit(trace_hit), .cmd_ok(cmd_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model: next state from the requirements and current inputs.
    task automatic model_step();
        bit fe, ft, live, texit;
        if (!rst_n) begin
            m_cnt = '0; m_dbg = ext_req && !sec_en; m_locked = sec_en;
            m_armed = 0; m_seen = 0; m_hit = 0; m_valid = 1;
            return;
        end
        live  = !m_dbg && !m_locked;
        fe    = live && ext_req && instr_done;
        ft    = live && m_armed && instr_done && (m_cnt == 0);
        texit = m_dbg && exit_dbg && m_seen;
        if (cnt_wr && !m_locked) m_cnt = cnt_wdata;
        else if (live && m_armed && instr_done && m_cnt != 0) m_cnt = m_cnt - 1;
        if (unlock_wr) m_locked = 0;
        if (texit) begin
            m_dbg = 0; m_hit = 0; m_armed = trace_en; m_seen = 0;
        end else if (m_dbg) begin
            if (!ext_req) m_seen = 1;
        end else if (fe || ft) begin
            m_dbg = 1; m_seen = 0; m_armed = 0; m_hit = ft;
        end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        if (m_valid) begin
            chk("model R7 halt_req", halt_req, m_dbg);
            chk("model R7 core_status", core_status, m_dbg ? 2'b11 : 2'b00);
            chk("model R7 ack_oe_n", ack_oe_n, !m_dbg);
            chk("model R4 cnt_rdata", cnt_rdata, m_cnt);
            chk("model R6 trace_hit", trace_hit, m_hit);
            chk("model R8 cmd_ok", cmd_ok, m_dbg && m_seen);
        end
    endtask

    task automatic idle();
        instr_done = 0; ext_req = 0; unlock_wr = 0; exit_dbg = 0; cnt_wr = 0;
    endtask

    task automatic do_reset(input bit sec, input bit req);
        idle(); rst_n = 0; sec_en = sec; ext_req = req;
        repeat (3) tick();
        rst_n = 1; sec_en = 0; ext_req = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        idle(); trace_en = 0; cnt_wdata = 0; sec_en = 0; rst_n = 0;
        @(negedge clk);

        // R1 reset state
        do_reset(0, 0);
        chk("R1 status", core_status, 2'b00);
        chk("R1 halt", halt_req, 0);
        chk("R1 ack", ack_oe_n, 1);
        chk("R1 cnt", cnt_rdata, 0);
        chk("R1 hit", trace_hit, 0);

        // R3 request without retire: no halt; with retire: halt
        ext_req = 1; tick();
        chk("R3 no retire", halt_req, 0);
        instr_done = 1; tick(); instr_done = 0;
        chk("R3 halt", halt_req, 1);
        chk("R7 status", core_status, 2'b11);
        chk("R7 ack", ack_oe_n, 0);
        chk("R8 cmd low", cmd_ok, 0);

        // R9 exit ignored while cmd_ok low
        exit_dbg = 1; tick(); exit_dbg = 0;
        chk("R9 early exit ignored", halt_req, 1);
        ext_req = 0; tick();
        chk("R8 cmd after release", cmd_ok, 1);

        // R4 write in debug, R13 no decrement while halted
        cnt_wr = 1; cnt_wdata = 16'd2; tick(); cnt_wr = 0;
        chk("R4 write", cnt_rdata, 2);
        instr_done = 1; tick(); instr_done = 0;
        chk("R13 halted hold", cnt_rdata, 2);

        // R9 exit with trace, R5 decrement, R6 halt after N=3 retires
        trace_en = 1; exit_dbg = 1; tick(); exit_dbg = 0;
        chk("R9 exit run", core_status, 2'b00);
        instr_done = 1; tick();
        chk("R5 dec 1", cnt_rdata, 1);
        tick();
        chk("R5 dec 0", cnt_rdata, 0);
        chk("R6 not yet", halt_req, 0);
        tick(); instr_done = 0;
        chk("R6 halt", halt_req, 1);
        chk("R6 hit", trace_hit, 1);

        // R10 exit without trace: counter idle
        tick(); trace_en = 0; exit_dbg = 1; tick(); exit_dbg = 0;
        chk("R9 hit cleared", trace_hit, 0);
        instr_done = 1; repeat (3) tick(); instr_done = 0;
        chk("R10 cnt", cnt_rdata, 0);
        chk("R10 no halt", halt_req, 0);

        // R4 write wins over decrement
        ext_req = 1; instr_done = 1; tick(); ext_req = 0; instr_done = 0; tick();
        cnt_wr = 1; cnt_wdata = 16'd5; tick(); cnt_wr = 0;
        trace_en = 1; exit_dbg = 1; tick(); exit_dbg = 0;
        cnt_wr = 1; cnt_wdata = 16'd9; instr_done = 1; tick(); cnt_wr = 0;
        chk("R4 write wins", cnt_rdata, 9);
        instr_done = 0;

        // R12 external request and trace expiry on the same retire
        cnt_wr = 1; cnt_wdata = 16'd0; tick(); cnt_wr = 0;
        ext_req = 1; instr_done = 1; tick(); ext_req = 0; instr_done = 0;
        chk("R12 halt", halt_req, 1);
        chk("R12 hit", trace_hit, 1);

        // R11 security lock
        do_reset(1, 1);
        chk("R11 reset req ignored", halt_req, 0);
        ext_req = 1; instr_done = 1; tick(); ext_req = 0; instr_done = 0;
        chk("R11 run req ignored", halt_req, 0);
        cnt_wr = 1; cnt_wdata = 16'd7; tick(); cnt_wr = 0;
        chk("R11 write ignored", cnt_rdata, 0);
        unlock_wr = 1; tick(); unlock_wr = 0;
        ext_req = 1; instr_done = 1; tick(); ext_req = 0; instr_done = 0;
        chk("R11 unlocked halt", halt_req, 1);

        // R2 request held during reset
        do_reset(0, 1);
        chk("R2 halt", halt_req, 1);
        chk("R2 status", core_status, 2'b11);
        chk("R2 ack", ack_oe_n, 0);
        chk("R2 cmd", cmd_ok, 0);

        // constrained random phase, judged by the model in tick()
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) == 0) begin
                do_reset($urandom_range(3) == 0, $urandom_range(1) == 1);
            end else begin
                instr_done = $urandom_range(1);
                ext_req    = $urandom_range(9) == 0;
                exit_dbg   = $urandom_range(4) == 0;
                cnt_wr     = $urandom_range(19) == 0;
                cnt_wdata  = 16'($urandom_range(6));
                trace_en   = $urandom_range(9) < 7;
                unlock_wr  = $urandom_range(49) == 0;
                tick();
            end
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule